// File: doc/BRIEF.md
# Auxiliary PWM Generator with Buffered Period and Compare

A single-channel PWM generator driven by an up-counter that runs from zero to the programmed period minus one and then wraps. A compare value decides how long the output stays in its asserted level in each period, and a polarity bit chooses whether that asserted level is high or low. A mode bit gates the output; while it is clear the pin is held low.

Software programs the block through a small write/read register port. While the generator is stopped, period and compare values go straight into the working (active) registers. While it runs, new values go into a second, buffered set that is copied into the working set only when the counter wraps, so a reprogramming never cuts a period short or stretches it.

Top module: `aux_pwm_shadow`

## Requirements
- R1: After reset the output is low, the counter is stopped at zero and every register reads back zero.
- R2: Byte addresses decode as: 0x08 working period, 0x0C working compare, 0x10 buffered period, 0x14 buffered compare, 0x2A control; each reads back what was last stored in it.
- R3: Control fields: bit 10 active-low polarity, bit 9 output mode enable, bits 7:6 sync select (stored and read back only), bit 4 counter run; every other control bit reads zero.
- R4: While run is set the counter steps 0, 1, ..., period-1 and wraps to 0; a period of 0 or 1 gives a one-cycle period.
- R5: While run is clear the counter is held at 0, so setting run again starts a period from count 0.
- R6: With polarity bit clear and mode set, the output one cycle after a count is high when that count is below the compare value; compare 0 gives a constantly low output and compare at or above the period a constantly high one.
- R7: With polarity bit set and mode set, the output is the inverse of the R6 level, so the compare value sets the low part of each period.
- R8: While mode is clear the output is low in the following cycle, whatever the polarity.
- R9: Writes to the buffered registers leave the working values untouched until the counter wraps; at that wrap both buffered values are copied to the working set.
- R10: A wrap with no buffered write since the last copy leaves the working values unchanged.
- R11: Writes to the working registers while run is set are ignored.
- R12: Period 1 with compare 1 gives a constantly high output under normal polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Counter and register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe, one register per cycle |
| bus_addr_i | input | ADDR_W | Byte address for read and write |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the current address, combinational |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The assertions take for granted that at most one register is written per cycle, that the working registers change only through the copy at a wrap or a write while stopped, and that the output level is judged one cycle after the count it reflects. The stimulus therefore issues single writes, programs working values only after the control register has stopped the counter, and measures duty cycles over windows that span whole periods so that the phase of the first sample does not matter. Buffered updates are given more than two full periods to settle because the two buffered writes may fall on either side of a wrap.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

    localparam int unsigned OFF_PRD_ACT = 'h08;
    localparam int unsigned OFF_CMP_ACT = 'h0C;
    localparam int unsigned OFF_PRD_BUF = 'h10;
    localparam int unsigned OFF_CMP_BUF = 'h14;
    localparam int unsigned OFF_CTRL    = 'h2A;

    localparam int unsigned CTRL_W        = 16;
    localparam int unsigned CTRL_POL_BIT  = 10;
    localparam int unsigned CTRL_MODE_BIT = 9;
    localparam int unsigned CTRL_SYNC_HI  = 7;
    localparam int unsigned CTRL_SYNC_LO  = 6;
    localparam int unsigned CTRL_RUN_BIT  = 4;

    typedef struct packed {
        logic       pol_low;
        logic       mode_en;
        logic [1:0] sync_sel;
        logic       run;
    } ctrl_t;

endpackage

// File: rtl/apwm_regfile.sv
module apwm_regfile
    import apwm_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wrap_i,
    output logic [DATA_W-1:0] rdata_o,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  prd_act_o,
    output logic [CNT_W-1:0]  cmp_act_o,
    output logic              pend_o
);

    localparam logic [ADDR_W-1:0] A_PRD_ACT = ADDR_W'(OFF_PRD_ACT);
    localparam logic [ADDR_W-1:0] A_CMP_ACT = ADDR_W'(OFF_CMP_ACT);
    localparam logic [ADDR_W-1:0] A_PRD_BUF = ADDR_W'(OFF_PRD_BUF);
    localparam logic [ADDR_W-1:0] A_CMP_BUF = ADDR_W'(OFF_CMP_BUF);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFF_CTRL);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] prd_act;
        logic [CNT_W-1:0] cmp_act;
        logic [CNT_W-1:0] prd_buf;
        logic [CNT_W-1:0] cmp_buf;
        logic             pend;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [CTRL_W-1:0] ctrl_rd;

    always_comb begin
        regs_d = regs_q;
        // Copy of the buffered set at a period boundary
        if (wrap_i && regs_q.pend) begin
            regs_d.prd_act = regs_q.prd_buf;
            regs_d.cmp_act = regs_q.cmp_buf;
            regs_d.pend    = 1'b0;
        end
        if (wr_i) begin
            case (addr_i)
                A_PRD_ACT: if (!regs_q.ctrl.run) regs_d.prd_act = wdata_i[CNT_W-1:0];
                A_CMP_ACT: if (!regs_q.ctrl.run) regs_d.cmp_act = wdata_i[CNT_W-1:0];
                A_PRD_BUF: begin
                    regs_d.prd_buf = wdata_i[CNT_W-1:0];
                    regs_d.pend    = 1'b1;
                end
                A_CMP_BUF: begin
                    regs_d.cmp_buf = wdata_i[CNT_W-1:0];
                    regs_d.pend    = 1'b1;
                end
                A_CTRL: begin
                    regs_d.ctrl.pol_low  = wdata_i[CTRL_POL_BIT];
                    regs_d.ctrl.mode_en  = wdata_i[CTRL_MODE_BIT];
                    regs_d.ctrl.sync_sel = wdata_i[CTRL_SYNC_HI:CTRL_SYNC_LO];
                    regs_d.ctrl.run      = wdata_i[CTRL_RUN_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    always_comb begin
        ctrl_rd                             = '0;
        ctrl_rd[CTRL_POL_BIT]               = regs_q.ctrl.pol_low;
        ctrl_rd[CTRL_MODE_BIT]              = regs_q.ctrl.mode_en;
        ctrl_rd[CTRL_SYNC_HI:CTRL_SYNC_LO]  = regs_q.ctrl.sync_sel;
        ctrl_rd[CTRL_RUN_BIT]               = regs_q.ctrl.run;
    end

    always_comb begin
        case (addr_i)
            A_PRD_ACT: rdata_o = DATA_W'(regs_q.prd_act);
            A_CMP_ACT: rdata_o = DATA_W'(regs_q.cmp_act);
            A_PRD_BUF: rdata_o = DATA_W'(regs_q.prd_buf);
            A_CMP_BUF: rdata_o = DATA_W'(regs_q.cmp_buf);
            A_CTRL:    rdata_o = DATA_W'(ctrl_rd);
            default:   rdata_o = '0;
        endcase
    end

    assign ctrl_o    = regs_q.ctrl;
    assign prd_act_o = regs_q.prd_act;
    assign cmp_act_o = regs_q.cmp_act;
    assign pend_o    = regs_q.pend;

endmodule

// File: rtl/apwm_counter.sv
module apwm_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [CNT_W-1:0] prd_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cstate_t;

    cstate_t cs_d, cs_q;
    logic    at_last;

    always_comb begin
        // Period 0 and 1 both behave as a one-cycle period
        at_last = (prd_i <= CNT_W'(1)) || (cs_q.cnt >= (prd_i - CNT_W'(1)));
        wrap_o  = run_i && at_last;
        cs_d    = cs_q;
        if (!run_i)       cs_d.cnt = '0;
        else if (at_last) cs_d.cnt = '0;
        else              cs_d.cnt = cs_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cs_q <= '0;
        else         cs_q <= cs_d;
    end

    assign cnt_o = cs_q.cnt;

endmodule

// File: rtl/apwm_output.sv
module apwm_output #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             pol_low_i,
    input  logic             mode_en_i,
    output logic             pwm_o
);

    typedef struct packed {
        logic level;
    } ostate_t;

    ostate_t os_d, os_q;
    logic    below;

    always_comb begin
        below = (cnt_i < cmp_i);
        os_d  = os_q;
        if (mode_en_i) os_d.level = below ^ pol_low_i;
        else           os_d.level = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) os_q <= '0;
        else         os_q <= os_d;
    end

    assign pwm_o = os_q.level;

endmodule

// File: rtl/aux_pwm_shadow.sv
module aux_pwm_shadow
    import apwm_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              pwm_o
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] prd_act;
    logic [CNT_W-1:0] cmp_act;
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic             pend;
    logic             run_en;
    logic             mode_en;

    assign run_en  = ctrl.run;
    assign mode_en = ctrl.mode_en;

    apwm_regfile #(
        .CNT_W (CNT_W),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .wrap_i   (wrap),
        .rdata_o  (bus_rdata_o),
        .ctrl_o   (ctrl),
        .prd_act_o(prd_act),
        .cmp_act_o(cmp_act),
        .pend_o   (pend)
    );

    apwm_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (run_en),
        .prd_i (prd_act),
        .cnt_o (cnt),
        .wrap_o(wrap)
    );

    apwm_output #(
        .CNT_W(CNT_W)
    ) u_out (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cnt_i    (cnt),
        .cmp_i    (cmp_act),
        .pol_low_i(ctrl.pol_low),
        .mode_en_i(mode_en),
        .pwm_o    (pwm_o)
    );

endmodule

// File: rtl/aux_pwm_shadow_chk.sv
module aux_pwm_shadow_chk
    import apwm_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              pwm_o,
    input logic              run_en,
    input logic              mode_en,
    input logic [CNT_W-1:0]  cnt,
    input logic              wrap,
    input logic [CNT_W-1:0]  prd_act,
    input logic [CNT_W-1:0]  cmp_act,
    input logic              pend
);

    logic buf_wr;
    assign buf_wr = bus_wr_i && ((bus_addr_i == ADDR_W'(OFF_PRD_BUF)) ||
                                 (bus_addr_i == ADDR_W'(OFF_CMP_BUF)));

    // R8: mode clear forces a low output in the next cycle
    p_low_mode_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_en |=> !pwm_o);

    // R4: the count never reaches the working period
    p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt == '0) || (cnt < prd_act));

    // R4: a wrap restarts the count at zero
    p_wrap_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> (cnt == '0));

    // R5: a stopped counter sits at zero
    p_stop_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_en |=> (cnt == '0));

    // R9 and R11: working values hold while running between wraps
    p_active_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_en && !wrap) |=> ($stable(prd_act) && $stable(cmp_act)));

    // R10: a wrap consumes the pending flag
    p_pend_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap && !buf_wr) |=> !pend);

endmodule

bind aux_pwm_shadow aux_pwm_shadow_chk #(
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_wr_i  (bus_wr_i),
    .bus_addr_i(bus_addr_i),
    .pwm_o     (pwm_o),
    .run_en    (run_en),
    .mode_en   (mode_en),
    .cnt       (cnt),
    .wrap      (wrap),
    .prd_act   (prd_act),
    .cmp_act   (cmp_act),
    .pend      (pend)
);

// File: tb/aux_pwm_shadow_bench.sv
module aux_pwm_shadow_bench;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_PA = 6'h08;
    localparam logic [ADDR_W-1:0] A_CA = 6'h0C;
    localparam logic [ADDR_W-1:0] A_PB = 6'h10;
    localparam logic [ADDR_W-1:0] A_CB = 6'h14;
    localparam logic [ADDR_W-1:0] A_CT = 6'h2A;

    localparam logic [31:0] C_RUN_MODE     = 32'h0210;
    localparam logic [31:0] C_RUN_MODE_INV = 32'h0610;
    localparam logic [31:0] C_RUN_INV      = 32'h0410;
    localparam logic [31:0] C_MODE         = 32'h0200;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              pwm;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    aux_pwm_shadow u_aux_pwm_shadow (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .bus_wr_i   (wr),
        .bus_addr_i (addr),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .pwm_o      (pwm)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Inputs change at a falling edge; returns at a falling edge
    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm) h++;
        end
    endtask

    task automatic setup(input logic [31:0] p, input logic [31:0] c);
        bus_write(A_CT, 32'h0);
        bus_write(A_PA, p);
        bus_write(A_CA, c);
        bus_write(A_PB, p);
        bus_write(A_CB, c);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1", {31'b0, pwm}, 32'h0);
        bus_read(A_PA, v); check("R1", v, 32'h0);
        bus_read(A_CB, v); check("R1", v, 32'h0);
        bus_read(A_CT, v); check("R1", v, 32'h0);
        idle(3);
        check("R1", {31'b0, pwm}, 32'h0);
    endtask

    task automatic t_regmap;
        logic [31:0] v;
        bus_write(A_PA, 32'h1234_5678);
        bus_write(A_CA, 32'h0BAD_F00D);
        bus_write(A_PB, 32'h0000_0777);
        bus_write(A_CB, 32'h00C0_FFEE);
        bus_read(A_PA, v); check("R2", v, 32'h1234_5678);
        bus_read(A_CA, v); check("R2", v, 32'h0BAD_F00D);
        bus_read(A_PB, v); check("R2", v, 32'h0000_0777);
        bus_read(A_CB, v); check("R2", v, 32'h00C0_FFEE);
        bus_write(A_CT, 32'hFFFF_FFFF);
        bus_read(A_CT, v); check("R3", v, 32'h0000_06D0);
        bus_write(A_CT, 32'h0000_00C0);
        bus_read(A_CT, v); check("R3", v, 32'h0000_00C0);
        bus_write(A_CT, 32'h0);
    endtask

    task automatic t_duty_normal;
        int h;
        setup(10, 3);
        bus_write(A_CT, C_RUN_MODE);
        idle(5);
        count_high(40, h); check("R6", h, 12);
        count_high(10, h); check("R4", h, 3);
    endtask

    task automatic t_cmp_edges;
        int h;
        setup(8, 0);
        bus_write(A_CT, C_RUN_MODE);
        idle(4);
        count_high(16, h); check("R6", h, 0);
        setup(8, 8);
        bus_write(A_CT, C_RUN_MODE);
        idle(4);
        count_high(16, h); check("R6", h, 16);
        setup(8, 12);
        bus_write(A_CT, C_RUN_MODE);
        idle(4);
        count_high(16, h); check("R6", h, 16);
    endtask

    task automatic t_inverted;
        int h;
        setup(10, 3);
        bus_write(A_CT, C_RUN_MODE_INV);
        idle(5);
        count_high(40, h); check("R7", h, 28);
    endtask

    task automatic t_mode_off;
        int h;
        setup(10, 3);
        bus_write(A_CT, C_RUN_INV);
        idle(2);
        count_high(20, h); check("R8", h, 0);
    endtask

    task automatic t_min_period;
        int h;
        setup(1, 1);
        bus_write(A_CT, C_RUN_MODE);
        idle(3);
        count_high(20, h); check("R12", h, 20);
    endtask

    task automatic t_stop_restart;
        int h;
        logic exp_seq [10] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
        setup(8, 3);
        bus_write(A_CT, C_RUN_MODE);
        idle(21);
        bus_write(A_CT, C_MODE);
        idle(3);
        // Count held at 0 and 0 < 3, so the output stays high
        count_high(10, h); check("R5", h, 10);
        bus_write(A_CT, C_RUN_MODE);
        for (int i = 0; i < 10; i++) begin
            if (i > 0) @(negedge clk);
            check("R5", {31'b0, pwm}, {31'b0, exp_seq[i]});
        end
    endtask

    task automatic t_shadow;
        logic [31:0] v;
        int h;
        setup(10, 3);
        bus_write(A_CT, C_RUN_MODE);
        idle(15);
        bus_write(A_PB, 20);
        bus_write(A_CB, 15);
        bus_read(A_PA, v); check("R9", v, 10);
        bus_read(A_CA, v); check("R9", v, 3);
        idle(50);
        bus_read(A_PA, v); check("R9", v, 20);
        bus_read(A_CA, v); check("R9", v, 15);
        count_high(40, h); check("R9", h, 30);
    endtask

    task automatic t_no_pending;
        logic [31:0] v;
        int h;
        bus_write(A_CT, 32'h0);
        bus_write(A_PA, 6);
        bus_write(A_CA, 2);
        bus_write(A_CT, C_RUN_MODE);
        idle(30);
        bus_read(A_PA, v); check("R10", v, 6);
        bus_read(A_CA, v); check("R10", v, 2);
        count_high(24, h); check("R10", h, 8);
    endtask

    task automatic t_active_ignored;
        logic [31:0] v;
        int h;
        bus_write(A_PA, 99);
        bus_write(A_CA, 1);
        bus_read(A_PA, v); check("R11", v, 6);
        bus_read(A_CA, v); check("R11", v, 2);
        count_high(24, h); check("R11", h, 8);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        t_reset;
        t_regmap;
        t_duty_normal;
        t_cmp_edges;
        t_inverted;
        t_mode_off;
        t_min_period;
        t_stop_restart;
        t_shadow;
        t_no_pending;
        t_active_ignored;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule